// File: doc/BRIEF.md
# Chained descriptor ring DMA engine

The block moves 32-bit words from one fixed local FIFO location into system memory. The work is described by a linked list of four-word descriptors that the engine fetches itself. Each descriptor names a memory start address, a local source address, a byte count and a pointer to the next descriptor. The low bits of that pointer carry flag bits. Descriptors and data share one simple synchronous memory port. A read returns its data on the cycle after the request, and a write completes on the cycle of the request.

Software writes the first descriptor pointer into a pointer register and then issues one control write with enable and start set. The engine then walks the chain with no further help. A word moves only while the FIFO side reports data, so the transfer is paced by demand. At the end of each link whose interrupt flag is set, the engine raises an interrupt. When the last link points back to the first, the ring never ends. The current memory address can be read at any time, so software can tell which link is being filled. An acknowledge write clears the interrupt and leaves the channel running. An abort write stops the channel at once.

Top module: `ring_dma`

## Requirements
- R1: After reset the engine is idle, with `active`, `irq` and `cfg_err` low. It issues no memory request until it is started.
- R2: A control write with `ctl_en` and `ctl_start` high and `ctl_abort` low starts the engine. It takes the pointer held in the pointer register and fetches four words at pointer+0, +4, +8 and +12, in this order: memory start address, local address, byte count, next pointer. The pointer bits [31:4] give the descriptor address.
- R3: The byte count is rounded down to whole 32-bit words, so a count of 10 moves 2 words. A count below 4 moves nothing, and the engine goes straight on to the next descriptor.
- R4: The words of a link are written to consecutive memory addresses, starting at the memory start address and stepping by 4. `cur_addr` shows the address of the next write. `fifo_addr` holds the local address field unchanged for the whole link.
- R5: A word is popped (`fifo_rd` high) only in a cycle where `fifo_ready` is high. Each pop writes that cycle's `fifo_data` to memory in the same cycle.
- R6: When a link's word count reaches zero and bit 1 of that descriptor's next pointer is set, `irq` goes high and stays high until it is cleared. A link with bit 1 clear raises no interrupt.
- R7: After a link ends, the engine fetches the descriptor at next pointer bits [31:4] times 16. A ring whose last link points to the first repeats forever. Next-pointer bits 0 and 2 (in host memory, local to host) are carried but change nothing.
- R8: A control write with `ctl_clr` high and `ctl_en` high clears `irq` and leaves `active` high. If a link ends in the same cycle, the new interrupt takes priority over the clear.
- R9: A control write with `ctl_abort` high, or with `ctl_en` low, takes effect in that cycle: no word moves and any descriptor fetch in progress is dropped. `active` is low from the next cycle on, and no further pops or memory requests happen.
- R10: Bit 3 of the starting pointer, or of a fetched next pointer, must be zero. If it is set, the engine goes idle and sets `cfg_err` instead of fetching. `cfg_err` stays high until the next start with a valid pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_we | input | 1 | Write the starting descriptor pointer register |
| desc_wdata | input | 32 | Starting pointer: address in [31:4], flag bits in [2:0], bit 3 must be zero |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_start | input | 1 | Start bit of the control write |
| ctl_clr | input | 1 | Interrupt clear bit of the control write |
| ctl_abort | input | 1 | Abort bit of the control write |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (low means read) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid on the cycle after a read request |
| fifo_rd | output | 1 | Pop one word from the FIFO |
| fifo_addr | output | 32 | Local source address of the current link |
| fifo_data | input | 32 | FIFO head word (show-ahead) |
| fifo_ready | input | 1 | FIFO has data available |
| cur_addr | output | 32 | Current memory write address |
| irq | output | 1 | Link-done interrupt |
| active | output | 1 | Channel is running |
| cfg_err | output | 1 | Misaligned descriptor pointer seen |

## Verification
The assertions assume a memory that always returns read data on the cycle after the request, with no stall. They also assume a show-ahead FIFO whose `fifo_data` is valid whenever `fifo_ready` is high. The bench's memory model and FIFO model give exactly that. `fifo_ready` is gated by the count of words still available, so it never claims data that does not exist. Random ready patterns and random descriptor sizes are generated from a fixed seed. Control writes are driven one cycle at a time, between clock edges, and the pointer register is never rewritten in the same cycle as a start.

// File: rtl/ring_dma.sv
module ring_dma (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        desc_we,
  input  logic [31:0] desc_wdata,
  input  logic        ctl_we,
  input  logic        ctl_en,
  input  logic        ctl_start,
  input  logic        ctl_clr,
  input  logic        ctl_abort,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        fifo_rd,
  output logic [31:0] fifo_addr,
  input  logic [31:0] fifo_data,
  input  logic        fifo_ready,
  output logic [31:0] cur_addr,
  output logic        irq,
  output logic        active,
  output logic        cfg_err
);
  localparam int BIT_IRQ = 1;
  localparam int BIT_BAD = 3;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FCAP, S_XFER} st_t;

  st_t         st;
  logic [1:0]  k;
  logic [31:0] dreg, nxt, cur, laddr;
  logic [27:0] dptr;
  logic [29:0] wcnt;
  logic        irq_q, err_q;

  wire stop     = ctl_we && (ctl_abort || !ctl_en);
  wire go       = ctl_we && ctl_en && ctl_start && !ctl_abort;
  wire hold     = stop || go;
  wire moving   = (st == S_XFER) && (wcnt != '0) && fifo_ready && !hold;
  wire fetch_rd = (st == S_FETCH) && !hold;
  wire link_end = (st == S_XFER) && (wcnt == '0) && !hold;
  wire irq_set  = link_end && nxt[BIT_IRQ];

  logic unused_flags;
  assign unused_flags = ^{dreg[2:0], nxt[2], nxt[0]};

  assign fifo_rd   = moving;
  assign mem_req   = moving || fetch_rd;
  assign mem_we    = moving;
  assign mem_addr  = moving ? cur : {dptr, 4'b0} + {28'b0, k, 2'b00};
  assign mem_wdata = fifo_data;
  assign fifo_addr = laddr;
  assign cur_addr  = cur;
  assign irq       = irq_q;
  assign active    = (st != S_IDLE);
  assign cfg_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; k <= '0; dreg <= '0; nxt <= '0; cur <= '0;
      laddr <= '0; dptr <= '0; wcnt <= '0; irq_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (desc_we) dreg <= desc_wdata;
      if (stop) begin
        st <= S_IDLE;
      end else if (go) begin
        if (dreg[BIT_BAD]) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else begin
          err_q <= 1'b0;
          dptr  <= dreg[31:4];
          k     <= '0;
          st    <= S_FETCH;
        end
      end else begin
        case (st)
          S_FETCH: st <= S_FCAP;
          S_FCAP: begin
            case (k)
              2'd0: cur   <= mem_rdata;
              2'd1: laddr <= mem_rdata;
              2'd2: wcnt  <= mem_rdata[31:2];
              default: nxt <= mem_rdata;
            endcase
            k  <= k + 2'd1;
            st <= (k == 2'd3) ? S_XFER : S_FETCH;
          end
          S_XFER: begin
            if (moving) begin
              cur  <= cur + 32'd4;
              wcnt <= wcnt - 30'd1;
            end else if (link_end) begin
              if (nxt[BIT_BAD]) begin
                err_q <= 1'b1;
                st    <= S_IDLE;
              end else begin
                dptr <= nxt[31:4];
                k    <= '0;
                st   <= S_FETCH;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
      if (irq_set) irq_q <= 1'b1;
      else if (ctl_we && ctl_clr) irq_q <= 1'b0;
    end
  end

  p_pop_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_ready);
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> cur_addr == $past(cur_addr) + 32'd4);
  p_local_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && $past(fifo_rd)) |-> fifo_addr == $past(fifo_addr));
  p_write_is_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active && !mem_req);
  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !active);
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_clr && !irq_set) |=> !irq);
endmodule

// File: tb/ring_dma_tb.sv
module ring_dma_tb;
  localparam int CLK_NS = 10;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_we = 1'b0; logic [31:0] desc_wdata = '0;
  logic ctl_we = 1'b0, ctl_en = 1'b0, ctl_start = 1'b0, ctl_clr = 1'b0, ctl_abort = 1'b0;
  logic mem_req, mem_we, fifo_rd, irq, active, cfg_err;
  logic [31:0] mem_addr, mem_wdata, fifo_addr, cur_addr;
  logic [31:0] mem_rdata = '0;
  logic rdy_rand = 1'b0;
  int avail = 0, popcnt = 0, reqcnt = 0;
  int vectors = 0, fails = 0;
  logic [31:0] mem [0:1023];
  wire fifo_ready = rdy_rand && (avail > 0);
  wire [31:0] fifo_data = 32'hC0DE0000 + popcnt;

  always #(CLK_NS/2) clk = ~clk;

  ring_dma u_dut (.clk, .rst_n, .desc_we, .desc_wdata, .ctl_we, .ctl_en, .ctl_start,
    .ctl_clr, .ctl_abort, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .fifo_rd, .fifo_addr, .fifo_data, .fifo_ready, .cur_addr, .irq, .active, .cfg_err);

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_req) reqcnt <= reqcnt + 1;
    if (fifo_rd) begin popcnt <= popcnt + 1; avail <= avail - 1; end
  end
  always @(negedge clk) rdy_rand <= ($urandom_range(0, 1) == 1);

  function automatic logic [31:0] pat(int n);
    return 32'hC0DE0000 + n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(logic en, logic st, logic clr, logic ab);
    @(negedge clk);
    ctl_we = 1'b1; ctl_en = en; ctl_start = st; ctl_clr = clr; ctl_abort = ab;
    @(negedge clk);
    ctl_we = 1'b0; ctl_en = 1'b0; ctl_start = 1'b0; ctl_clr = 1'b0; ctl_abort = 1'b0;
  endtask

  task automatic set_ptr(logic [31:0] p);
    @(negedge clk); desc_we = 1'b1; desc_wdata = p;
    @(negedge clk); desc_we = 1'b0;
  endtask

  task automatic put_desc(int a, logic [31:0] ma, logic [31:0] la, logic [31:0] sz, logic [31:0] nx);
    mem[a/4] = ma; mem[a/4+1] = la; mem[a/4+2] = sz; mem[a/4+3] = nx;
  endtask

  task automatic supply(int n);
    int target;
    @(negedge clk);
    target = popcnt + n;
    avail = avail + n;
    for (int g = 0; g < 5000 && popcnt < target; g++) @(negedge clk);
    repeat (120) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int base, rq;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = SENT;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 active", {31'b0, active}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 cfg_err", {31'b0, cfg_err}, 0);
    chk("R1 no requests", reqcnt, 0);

    put_desc(32'h100, 32'h400, 32'h1818, 32'd16, 32'h110 | 32'h7);
    put_desc(32'h110, 32'h500, 32'h1818, 32'd10, 32'h120 | 32'h5);
    put_desc(32'h120, 32'h600, 32'h1818, 32'd0,  32'h100 | 32'h1);
    set_ptr(32'h100 | 32'h7);
    base = popcnt;
    ctl(1, 1, 1, 0);
    chk("R2 started", {31'b0, active}, 1);
    supply(4);
    for (int j = 0; j < 4; j++) chk("R4 link0 word", mem[32'h400/4 + j], pat(base + j));
    chk("R4 local address", fifo_addr, 32'h1818);
    chk("R7 next link address", cur_addr, 32'h500);
    chk("R6 flagged link irq", {31'b0, irq}, 1);
    chk("R5 pops bounded by ready", popcnt, base + 4);
    ctl(1, 0, 1, 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    chk("R8 still active", {31'b0, active}, 1);

    supply(2);
    chk("R3 rounded word0", mem[32'h500/4], pat(base + 4));
    chk("R3 rounded word1", mem[32'h500/4 + 1], pat(base + 5));
    chk("R3 rounded tail untouched", mem[32'h500/4 + 2], SENT);
    chk("R3 zero link untouched", mem[32'h600/4], SENT);
    chk("R6 unflagged links no irq", {31'b0, irq}, 0);
    chk("R7 ring wraps", cur_addr, 32'h400);

    supply(3);
    for (int j = 0; j < 3; j++) chk("R7 second lap", mem[32'h400/4 + j], pat(base + 6 + j));
    chk("R7 second lap old word", mem[32'h400/4 + 3], pat(base + 3));
    chk("R4 cur address mid link", cur_addr, 32'h40C);

    ctl(0, 0, 0, 1);
    chk("R9 abort idle", {31'b0, active}, 0);
    rq = reqcnt;
    supply(2);
    chk("R9 no pops after abort", popcnt, base + 9);
    chk("R9 no requests after abort", reqcnt, rq);
    chk("R9 memory untouched", mem[32'h400/4 + 3], pat(base + 3));
    @(negedge clk); avail = 0;

    set_ptr(32'h108);
    ctl(1, 1, 1, 0);
    chk("R10 bad start pointer err", {31'b0, cfg_err}, 1);
    chk("R10 bad start idle", {31'b0, active}, 0);
    chk("R10 no fetch", reqcnt, rq);

    put_desc(32'h200, 32'h700, 32'h0, 32'd4, 32'h218 | 32'h2);
    set_ptr(32'h200);
    base = popcnt;
    ctl(1, 1, 1, 0);
    chk("R10 err cleared on good start", {31'b0, cfg_err}, 0);
    supply(1);
    chk("R10 word before bad next", mem[32'h700/4], pat(base));
    chk("R10 bad next err", {31'b0, cfg_err}, 1);
    chk("R10 bad next idle", {31'b0, active}, 0);
    chk("R6 irq on flagged link", {31'b0, irq}, 1);

    for (int r = 0; r < 3; r++) begin
      int sz [4];
      logic fl [4];
      int tot, off;
      logic exp_irq;
      tot = 0; exp_irq = 1'b0;
      for (int i = 0; i < 4; i++) begin
        sz[i] = (i == 0) ? 4 + $urandom_range(0, 19) : $urandom_range(0, 23);
        fl[i] = ($urandom_range(0, 1) == 1);
        exp_irq = exp_irq | fl[i];
        tot += sz[i] / 4;
        for (int j = 0; j < 16; j++) mem[(32'h800 + i*32'h40)/4 + j] = SENT;
        put_desc(32'h300 + i*16, 32'h800 + i*32'h40, 32'h2000 + r,
                 sz[i], (32'h300 + ((i+1)%4)*16) | {30'b0, fl[i], 1'b1});
      end
      set_ptr(32'h300);
      base = popcnt;
      ctl(1, 1, 1, 0);
      supply(tot);
      off = 0;
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < sz[i]/4; j++)
          chk("R4 random word", mem[(32'h800 + i*32'h40)/4 + j], pat(base + off + j));
        chk("R3 random tail", mem[(32'h800 + i*32'h40)/4 + sz[i]/4], SENT);
        off += sz[i]/4;
      end
      chk("R7 random wrap", cur_addr, 32'h800);
      chk("R6 random irq", {31'b0, irq}, {31'b0, exp_irq});
      ctl(0, 0, 1, 1);
      @(negedge clk); avail = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule